// File: doc/BRIEF.md
# Shared-Port Fetch Stall Controller

This block sits beside a five-stage in-order pipeline (fetch, decode with register read, execute with address calculation, memory access, write-back) whose instruction fetches and data loads and stores go through one memory port. In each cycle it decides which of the two claimants owns the port. A load or store in the memory stage always wins. A fetch that loses is held back and tried again in the next cycle. While a fetch is held, the program counter and the fetch/decode latch keep their values.

A cycle in which no instruction is fetched leaves the decode stage empty in the next cycle. The controller keeps one bubble flag for each stage after fetch. Each flag moves one stage per cycle, so the surrounding logic can clear the valid bit of the slot it describes. A bubble slot makes no memory access and writes no register. The controller also produces the fetch address, which starts at zero after reset and advances by a fixed step on each granted fetch.

The sequencing is a three-state machine that records what happened to the fetch slot in the previous cycle. ST_IDLE means no fetch was requested, and it is also the state after reset. ST_FETCH means a fetch was granted. ST_STOLEN means a fetch was requested but the port went to a data access. Every cycle the machine moves to ST_FETCH when a fetch is granted, to ST_STOLEN when a requested fetch loses the port, and to ST_IDLE when there is no request. The decode bubble flag is set in every state except ST_FETCH.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: When mem_valid is 1 and mem_load is 1, the port goes to the memory stage in the same cycle: port_to_data=1, addr_sel=1 (1 selects the data address, 0 the fetch address) and port_to_fetch=0.
- R2: A store (mem_valid=1, mem_store=1, mem_load=0) claims the port exactly as a load does, with the same output values as R1.
- R3: When fetch_req is 1 and no data access claims the port, port_to_fetch=1, port_to_data=0 and addr_sel=0 in the same cycle.
- R4: pc_en and ifid_en are both 1 exactly when a fetch is granted. Otherwise both are 0 and fetch_pc holds its value.
- R5: fetch_pc is 0 after reset and increases by STEP (default 4) at each clock edge where a fetch is granted.
- R6: stage_bubble[0] (decode) is 1 in the cycle after a cycle with no granted fetch, whether the fetch was stolen or not requested, and 0 in the cycle after a granted fetch.
- R7: For k = 1..3, stage_bubble[k] equals stage_bubble[k-1] of the previous cycle. Bit 1 is execute, bit 2 is memory and bit 3 is write-back.
- R8: During reset and in the first cycle after it, all four stage_bubble bits are 1 and fetch_pc is 0.
- R9: mem_load and mem_store have no effect when mem_valid is 0: a requested fetch is granted and port_to_data stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch stage wants the port |
| mem_valid | input | 1 | Memory-stage slot holds a real instruction |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| port_to_data | output | 1 | Port granted to the memory stage |
| port_to_fetch | output | 1 | Port granted to the fetch stage |
| addr_sel | output | 1 | Address mux select, 1 = data address |
| pc_en | output | 1 | Program counter update enable |
| ifid_en | output | 1 | Fetch/decode latch load enable |
| fetch_pc | output | AW | Current fetch address |
| stage_bubble | output | 4 | Bubble flags: [0] decode, [1] execute, [2] memory, [3] write-back |

## Verification
The hardest case to reach from the ports is a series of bubbles that overlap in the pipeline: stolen fetches and idle cycles mixed back to back, so that several flags are in flight at once in different positions. The stimulus steps through every ordered pair of the sixteen input combinations in consecutive cycles, and then a long pseudo-random run. A bench model shifts the expected flags and adds up the expected address, so every overlap pattern and every hold after a loss is compared cycle by cycle.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    // Number of stages behind fetch that carry a bubble flag
    localparam int TRACK_STAGES = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_STOLEN = 2'd2
    } slot_state_t;
endpackage

// File: rtl/fsc_owner_fsm.sv
module fsc_owner_fsm
    import fsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_req,
    input  logic mem_valid,
    input  logic mem_load,
    input  logic mem_store,
    output logic grant_data,
    output logic grant_fetch,
    output logic decode_empty
);
    slot_state_t state, state_nx;
    logic        data_claim;

    assign data_claim  = mem_valid && (mem_load || mem_store);
    assign grant_data  = data_claim;
    assign grant_fetch = fetch_req && !data_claim;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state: what happens to this cycle's fetch slot
    always_comb begin
        if (grant_fetch)    state_nx = ST_FETCH;
        else if (fetch_req) state_nx = ST_STOLEN;
        else                state_nx = ST_IDLE;
    end

    // Output decode from the state
    always_comb begin
        unique case (state)
            ST_FETCH:  decode_empty = 1'b0;
            ST_STOLEN: decode_empty = 1'b1;
            ST_IDLE:   decode_empty = 1'b1;
            default:   decode_empty = 1'b1;
        endcase
    end
endmodule

// File: rtl/fsc_bubble_shift.sv
module fsc_bubble_shift #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         head,
    output logic [N-1:0] flags
);
    assign flags[0] = head;

    for (genvar k = 1; k < N; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) flags[k] <= 1'b1;
            else        flags[k] <= flags[k-1];
        end
    end
endmodule

// File: rtl/fsc_pc_reg.sv
module fsc_pc_reg #(
    parameter int AW   = 16,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    always_ff @(posedge clk) begin
        if (!rst_n)  pc <= '0;
        else if (en) pc <= pc + STEP_V;
    end
endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl
    import fsc_pkg::*;
#(
    parameter int AW   = 16,
    parameter int STEP = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fetch_req,
    input  logic                    mem_valid,
    input  logic                    mem_load,
    input  logic                    mem_store,
    output logic                    port_to_data,
    output logic                    port_to_fetch,
    output logic                    addr_sel,
    output logic                    pc_en,
    output logic                    ifid_en,
    output logic [AW-1:0]           fetch_pc,
    output logic [TRACK_STAGES-1:0] stage_bubble
);
    logic g_data, g_fetch, dec_empty;

    fsc_owner_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_req    (fetch_req),
        .mem_valid    (mem_valid),
        .mem_load     (mem_load),
        .mem_store    (mem_store),
        .grant_data   (g_data),
        .grant_fetch  (g_fetch),
        .decode_empty (dec_empty)
    );

    fsc_bubble_shift #(.N(TRACK_STAGES)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .head  (dec_empty),
        .flags (stage_bubble)
    );

    fsc_pc_reg #(.AW(AW), .STEP(STEP)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (g_fetch),
        .pc    (fetch_pc)
    );

    assign port_to_data  = g_data;
    assign port_to_fetch = g_fetch;
    assign addr_sel      = g_data;
    assign pc_en         = g_fetch;
    assign ifid_en       = g_fetch;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int AW   = 16,
    parameter int STEP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_req,
    input logic          mem_valid,
    input logic          mem_load,
    input logic          mem_store,
    input logic          port_to_data,
    input logic          port_to_fetch,
    input logic          addr_sel,
    input logic          pc_en,
    input logic          ifid_en,
    input logic [AW-1:0] fetch_pc,
    input logic [3:0]    stage_bubble
);
    assert_load_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_load) |-> (port_to_data && addr_sel && !port_to_fetch));

    assert_store_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_store) |-> (port_to_data && !port_to_fetch));

    assert_fetch_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !(mem_valid && (mem_load || mem_store))) |-> (port_to_fetch && !addr_sel));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en |=> $stable(fetch_pc));

    assert_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_en == ifid_en) && (pc_en == port_to_fetch));

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_en |=> (fetch_pc == $past(fetch_pc) + AW'(STEP)));

    assert_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        port_to_fetch |=> !stage_bubble[0]);

    assert_head_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !port_to_fetch |=> stage_bubble[0]);

    assert_travel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stage_bubble[3:1] == $past(stage_bubble[2:0])));

    assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && fetch_req) |-> (port_to_fetch && !port_to_data));
endmodule

bind fetch_stall_ctrl fsc_checker #(.AW(AW), .STEP(STEP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_req     (fetch_req),
    .mem_valid     (mem_valid),
    .mem_load      (mem_load),
    .mem_store     (mem_store),
    .port_to_data  (port_to_data),
    .port_to_fetch (port_to_fetch),
    .addr_sel      (addr_sel),
    .pc_en         (pc_en),
    .ifid_en       (ifid_en),
    .fetch_pc      (fetch_pc),
    .stage_bubble  (stage_bubble)
);

// File: tb/sim_fetch_stall_ctrl.sv
`timescale 1ns/1ps
module sim_fetch_stall_ctrl;
    localparam int AW   = 16;
    localparam int STEP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_req = 1'b0, mem_valid = 1'b0, mem_load = 1'b0, mem_store = 1'b0;
    logic          port_to_data, port_to_fetch, addr_sel, pc_en, ifid_en;
    logic [AW-1:0] fetch_pc;
    logic [3:0]    stage_bubble;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [AW-1:0] exp_pc;
    logic [3:0]    exp_b;

    always #10 clk = ~clk;

    fetch_stall_ctrl #(.AW(AW), .STEP(STEP)) u0 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .mem_valid(mem_valid),
        .mem_load(mem_load), .mem_store(mem_store), .port_to_data(port_to_data),
        .port_to_fetch(port_to_fetch), .addr_sel(addr_sel), .pc_en(pc_en),
        .ifid_en(ifid_en), .fetch_pc(fetch_pc), .stage_bubble(stage_bubble)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check before posedge, update model at posedge
    task automatic step(input logic [3:0] v);
        logic claim, grant;
        @(negedge clk);
        fetch_req = v[0]; mem_valid = v[1]; mem_load = v[2]; mem_store = v[3];
        #2;
        claim = v[1] && (v[2] || v[3]);
        grant = v[0] && !claim;
        if (v[1] && v[2])
            chk(port_to_data && addr_sel && !port_to_fetch, "R1",
                {port_to_data, addr_sel, port_to_fetch}, 3'b110);
        if (v[1] && v[3] && !v[2])
            chk(port_to_data && addr_sel && !port_to_fetch, "R2",
                {port_to_data, addr_sel, port_to_fetch}, 3'b110);
        if (grant)
            chk(port_to_fetch && !port_to_data && !addr_sel, "R3",
                {port_to_data, addr_sel, port_to_fetch}, 3'b001);
        if (!v[1] && v[0])
            chk(port_to_fetch && !port_to_data, "R9",
                {port_to_data, port_to_fetch}, 2'b01);
        chk(pc_en == grant && ifid_en == grant, "R4", {pc_en, ifid_en}, {grant, grant});
        chk(fetch_pc == exp_pc, "R5", fetch_pc, exp_pc);
        chk(stage_bubble[0] == exp_b[0], "R6", stage_bubble[0], exp_b[0]);
        chk(stage_bubble[3:1] == exp_b[3:1], "R7", stage_bubble[3:1], exp_b[3:1]);
        @(posedge clk);
        exp_b = {exp_b[2:0], ~grant};
        if (grant) exp_pc = exp_pc + AW'(STEP);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lfsr;
        exp_pc = '0;
        exp_b  = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: state during reset
        chk(stage_bubble == 4'hF, "R8", stage_bubble, 4'hF);
        chk(fetch_pc == '0, "R8", fetch_pc, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(stage_bubble == 4'hF, "R8", stage_bubble, 4'hF);
        chk(fetch_pc == '0, "R8", fetch_pc, 0);

        // Every ordered pair of input combinations in consecutive cycles
        for (int i = 0; i < 256; i++) begin
            step(i[3:0]);
            step(i[7:4]);
        end
        // Directed: long run of stolen fetches, then recovery
        for (int i = 0; i < 5; i++) step(4'b0111);
        for (int i = 0; i < 6; i++) step(4'b0001);
        // Pseudo-random tail
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[3:0]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule